// File: doc/BRIEF.md
# Run-length expander with loadable length table

The block turns a stream of compressed records into a stream of plain values. Each record holds a value and a length field. The block repeats the value on its output as many times as the resolved length says. A record is taken over a valid/ready handshake, and each repeated value leaves over a second valid/ready handshake.

The length can be resolved in two ways, selected per record by a mode bit that travels with the record. In direct mode the length field itself is the repeat count. In indexed mode the low bits of the length field address a small length table inside the block, and the selected entry is the repeat count. A separate write port loads the table, so each compressed stream can bring its own set of common run lengths. A loaded count sits in a down-counter. The value is repeated until that counter runs out. The next record can be taken in the cycle that emits the last value of the current run.

Top module: `rle_expander`

## Requirements
- R1: A record accepted at a clock edge (in_valid and in_ready both high) appears on out_value, with out_valid high, right after that edge.
- R2: With in_indexed = 0, a record emits exactly in_len copies of in_value, for in_len from 1 to 255.
- R3: With in_indexed = 1, a record emits as many copies as the table entry addressed by in_len[3:0]. Bits in_len[7:4] have no effect on the count.
- R4: A resolved length of zero, from either mode, emits exactly one copy.
- R5: When out_ready is high, in_ready is high in the cycle of the last copy of a run. Back-to-back records then produce their copies in consecutive cycles, with no idle cycle between them.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_value stays unchanged. No copy is lost or added because of the stall.
- R7: tbl_accept is high for a table write (tbl_we) exactly when no indexed-mode run is in progress. A refused write leaves the entry unchanged. An accepted write, including one made during a direct-mode run, stores tbl_data at tbl_addr.
- R8: A synchronous reset (rst high at a clock edge) drops out_valid, raises in_ready and abandons the current run. The table contents survive the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A record is offered |
| in_ready | output | 1 | The block takes the offered record at this edge |
| in_value | input | VAL_W | Value to repeat |
| in_len | input | LEN_W | Repeat count (direct mode) or table index in the low IDX_W bits (indexed mode) |
| in_indexed | input | 1 | 1 selects indexed mode for this record |
| tbl_we | input | 1 | Table write request |
| tbl_addr | input | IDX_W | Table entry to write |
| tbl_data | input | LEN_W | Repeat count to store |
| tbl_accept | output | 1 | The table write is taken at this edge |
| out_valid | output | 1 | An expanded value is available |
| out_ready | input | 1 | The consumer takes the value at this edge |
| out_value | output | VAL_W | Expanded value |

## Verification
The bench checks how the counter handles its end points. A zero length must still emit one copy, and an off-by-one counter would emit one copy too many or too few. Back-to-back records are timed cycle by cycle, because a design that raised in_ready only after the run finished would leave a one-cycle bubble between runs. Alternating backpressure checks that a stalled value is held and that the count does not decrement during a stall. Table writes are attempted during an indexed run, during a direct run and after a reset, to catch a design that corrupts a count in flight, refuses writes it should take, or clears the table on reset.

// File: rtl/rle_expander.sv
`timescale 1ns/1ps
module rle_expander #(
  parameter int VAL_W = 8,
  parameter int LEN_W = 8,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VAL_W-1:0] in_value,
  input  logic [LEN_W-1:0] in_len,
  input  logic             in_indexed,
  input  logic             tbl_we,
  input  logic [IDX_W-1:0] tbl_addr,
  input  logic [LEN_W-1:0] tbl_data,
  output logic             tbl_accept,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VAL_W-1:0] out_value
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LEN_W-1:0] len_tbl [DEPTH];
  logic [LEN_W-1:0] rem;
  logic [VAL_W-1:0] cur_val;
  logic             active;
  logic             run_idx;

  wire              last    = active && (rem == '0);
  wire              take    = in_valid && in_ready;
  wire [LEN_W-1:0]  res_len = in_indexed ? len_tbl[in_len[IDX_W-1:0]] : in_len;

  assign in_ready   = !active || (out_ready && last);
  assign tbl_accept = tbl_we && !(active && run_idx);
  assign out_valid  = active;
  assign out_value  = cur_val;

  always_ff @(posedge clk) begin
    if (tbl_accept) len_tbl[tbl_addr] <= tbl_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      rem     <= '0;
      run_idx <= 1'b0;
      cur_val <= '0;
    end else if (take) begin
      active  <= 1'b1;
      cur_val <= in_value;
      run_idx <= in_indexed;
      rem     <= (res_len == '0) ? '0 : res_len - 1'b1;
    end else if (active && out_ready) begin
      if (last) active <= 1'b0;
      else      rem    <= rem - 1'b1;
    end
  end

  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid && out_value == $past(in_value)); // R1

  AST_ZERO_ONE: assert property (@(posedge clk) disable iff (rst)
    (take && res_len == '0) |=> out_valid && (!out_ready || in_ready)); // R4

  AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (rst)
    take |-> (!out_valid || out_ready)); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_value)); // R6

  AST_RESET_DROP: assert property (@(posedge clk)
    rst |=> !out_valid && in_ready); // R8
endmodule

// File: tb/rle_expander_tb.sv
`timescale 1ns/1ps
module rle_expander_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_value = '0;
  logic [7:0] in_len = '0;
  logic       in_indexed = 1'b0;
  logic       tbl_we = 1'b0;
  logic [3:0] tbl_addr = '0;
  logic [7:0] tbl_data = '0;
  logic       tbl_accept;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_value;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int rdy_mode = 1;
  int n_obs   = 0;
  logic [7:0] obs_val [64];
  int         obs_cyc [64];
  logic       stalled = 1'b0;
  logic [7:0] stall_val = '0;
  int         hold_err = 0;

  rle_expander dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_len(in_len), .in_indexed(in_indexed),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_data(tbl_data),
    .tbl_accept(tbl_accept), .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1;
    case (rdy_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = cyc[0];
    endcase
  end

  always @(negedge clk) begin
    if (rst) begin
      stalled = 1'b0;
    end else begin
      if (stalled && !(out_valid && out_value == stall_val)) hold_err++;
      stalled   = out_valid && !out_ready;
      stall_val = out_value;
      if (out_valid && out_ready && n_obs < 64) begin
        obs_val[n_obs] = out_value;
        obs_cyc[n_obs] = cyc;
        n_obs++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send_rec(input logic [7:0] v, input logic [7:0] l, input logic ix);
    in_valid = 1'b1; in_value = v; in_len = l; in_indexed = ix;
    do @(negedge clk); while (!in_ready);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic drain;
    do @(negedge clk); while (out_valid);
    @(posedge clk); #1;
  endtask

  task automatic tbl_write(input logic [3:0] a, input logic [7:0] d, input bit exp_acc, input string tag);
    tbl_we = 1'b1; tbl_addr = a; tbl_data = d;
    @(negedge clk);
    chk(tbl_accept == exp_acc, tag, tbl_accept, exp_acc);
    @(posedge clk); #1;
    tbl_we = 1'b0;
  endtask

  task automatic run_one(input logic [7:0] v, input logic [7:0] l, input logic ix, input int exp_n, input string tag);
    n_obs = 0;
    send_rec(v, l, ix);
    drain();
    chk(n_obs == exp_n, tag, n_obs, exp_n);
    for (int i = 0; i < n_obs; i++)
      if (obs_val[i] != v) begin chk(0, tag, obs_val[i], v); break; end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R8 reset in_ready", in_ready, 1);
    @(posedge clk); #1;
  endtask

  task automatic t_direct;
    rdy_mode = 1;
    run_one(8'hA5, 8'd3, 1'b0, 3, "R2 direct len3");
    run_one(8'h5A, 8'd1, 1'b0, 1, "R2 direct len1");
    run_one(8'h3C, 8'd40, 1'b0, 40, "R2 direct len40");
  endtask

  task automatic t_load;
    tbl_write(4'd2, 8'd5, 1'b1, "R7 idle write 2");
    tbl_write(4'd7, 8'd0, 1'b1, "R7 idle write 7");
    tbl_write(4'd15, 8'd9, 1'b1, "R7 idle write 15");
  endtask

  task automatic t_indexed;
    rdy_mode = 1;
    run_one(8'h11, 8'hF2, 1'b1, 5, "R3 indexed entry2 high bits set");
    run_one(8'h22, 8'h0F, 1'b1, 9, "R3 indexed entry15");
  endtask

  task automatic t_zero;
    rdy_mode = 1;
    run_one(8'h44, 8'd0, 1'b0, 1, "R4 direct zero");
    run_one(8'h55, 8'h07, 1'b1, 1, "R4 indexed zero entry");
  endtask

  task automatic t_b2b;
    logic [7:0] exp_v [6];
    exp_v = '{8'h01, 8'h01, 8'h02, 8'h03, 8'h03, 8'h03};
    rdy_mode = 1;
    n_obs = 0;
    send_rec(8'h01, 8'd2, 1'b0);
    send_rec(8'h02, 8'd1, 1'b0);
    send_rec(8'h03, 8'd3, 1'b0);
    drain();
    chk(n_obs == 6, "R5 b2b count", n_obs, 6);
    if (n_obs == 6) begin
      chk(obs_cyc[5] - obs_cyc[0] == 5, "R5 b2b no bubble span", obs_cyc[5] - obs_cyc[0], 5);
      for (int i = 0; i < 6; i++)
        chk(obs_val[i] == exp_v[i], "R5 b2b order", obs_val[i], exp_v[i]);
    end
  endtask

  task automatic t_backpressure;
    rdy_mode = 2;
    hold_err = 0;
    run_one(8'h33, 8'd4, 1'b0, 4, "R6 stall count direct");
    run_one(8'h66, 8'h02, 1'b1, 5, "R6 stall count indexed");
    chk(hold_err == 0, "R6 stall hold", hold_err, 0);
    rdy_mode = 1;
  endtask

  task automatic t_refuse;
    rdy_mode = 0;
    n_obs = 0;
    send_rec(8'h77, 8'h02, 1'b1);
    tbl_write(4'd2, 8'd1, 1'b0, "R7 refused during indexed run");
    rdy_mode = 1;
    drain();
    chk(n_obs == 5, "R7 run intact", n_obs, 5);
    run_one(8'h78, 8'h02, 1'b1, 5, "R7 entry unchanged");
    rdy_mode = 0;
    n_obs = 0;
    send_rec(8'h79, 8'd2, 1'b0);
    tbl_write(4'd3, 8'd2, 1'b1, "R7 accepted during direct run");
    rdy_mode = 1;
    drain();
    chk(n_obs == 2, "R7 direct run count", n_obs, 2);
    run_one(8'h7A, 8'h03, 1'b1, 2, "R7 new entry used");
  endtask

  task automatic t_reset_mid;
    rdy_mode = 0;
    send_rec(8'h99, 8'd10, 1'b0);
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 mid-run reset out_valid", out_valid, 0);
    chk(in_ready == 1'b1, "R8 mid-run reset in_ready", in_ready, 1);
    rdy_mode = 1;
    @(posedge clk); #1;
    run_one(8'hAA, 8'h02, 1'b1, 5, "R8 table kept");
    run_one(8'hAB, 8'd2, 1'b0, 2, "R1 after reset");
  endtask

  initial begin
    #2_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_direct();
    t_load();
    t_indexed();
    t_zero();
    t_b2b();
    t_backpressure();
    t_refuse();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule